// File: doc/BRIEF.md
# Shared SPI Bus Router with Clock-Enable Pipeline

This block sits between a single SPI master and several physically separate slave buses on one RF card. The master provides its serial clock, serial data out, an active-low chip select and a 4-bit device code. The router decodes the device code into a target bus and a chip-select line on that bus. It drives the master's clock and data onto that bus only, and it pulls the chosen chip select low only while the master's chip select is asserted. The serial data returned by the slave on the selected bus goes back to the master. Buses that cannot be read, and codes that select nothing, return 0.

All routed outputs pass through two register stages. Each stage advances only when the master's double-rate clock enable is high. That enable pulses twice per serial-clock period, so the slaves see every edge exactly one serial-clock period late. The master shifts its own sampling point by that amount. Returned data passes through two more stages paced by the same enable. Every slave idles the serial clock low and samples on the rising edge, so a pure delay of the master's waveform is enough and no edge conversion is needed.

Device-code map: 0 selects the converter bus (bus 0, one chip select, flat line 0). Codes 2 and 3 select bus 1 (two chip selects, flat lines 1 and 2). Codes 4, 5 and 6 select bus 2 (three chip selects, flat lines 3, 4 and 5). Every other code is unused.

Top module: `spi_bus_router`

## Requirements
- R1: While reset is held and after it is released, every bus serial clock and data line is 0, all six chip-select lines are 1, and the returned master data is 0.
- R2: A change on the master inputs reaches the bus outputs on the second rising clock edge at which the clock enable is high, and not on the first.
- R3: On a rising clock edge with the clock enable low, no bus output and no returned data bit changes.
- R4: Device code 0 with the master chip select low drives flat chip-select line 0 low and copies the master clock and data onto bus 0 (bit 0 of the bus vectors).
- R5: Device codes 2 and 3 drive flat chip-select lines 1 and 2 low, respectively, and route clock and data onto bus 1 (bit 1).
- R6: Device codes 4, 5 and 6 drive flat chip-select lines 3, 4 and 5 low, respectively, and route clock and data onto bus 2 (bit 2).
- R7: The serial clock and data lines of every bus that is not selected stay 0.
- R8: Device codes 1 and 7 to 15 drive no chip select low and leave every bus clock and data line at 0.
- R9: When the master chip select is high, all six chip-select lines are high, whatever the device code.
- R10: The returned data bit of the selected bus reaches the master output two enable edges after the routed outputs have settled. Bus 1 is write-only and returns 0, and so does any unused code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_ce | input | 1 | Clock enable at twice the serial-clock rate |
| m_sclk | input | 1 | Master serial clock |
| m_mosi | input | 1 | Master serial data out |
| m_cs_n | input | 1 | Master chip select, active low |
| m_sel | input | 4 | Device code |
| m_miso | output | 1 | Returned serial data to the master |
| bus_sclk | output | 3 | Serial clock per bus |
| bus_mosi | output | 3 | Serial data per bus |
| bus_cs_n | output | 6 | Flat chip-select lines, active low (bus 0: 0; bus 1: 1-2; bus 2: 3-5) |
| bus_miso | input | 3 | Returned serial data per bus |

## Verification
The assertions assume that the clock enable is a single-cycle strobe sampled on the system clock, and that the device code and master lines change only between enable strobes. That way each stage captures a stable value. The bench drives every input on the falling edge and raises the enable for exactly one rising edge at a time, so it meets both conditions. It holds the enable low for long stretches to test the hold behaviour. The one-hot chip-select property also relies on the decode never naming two lines, which holds for every one of the 16 codes that the bench walks.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;
  localparam int SEL_W = 4;
  localparam int NBUS  = 3;
  localparam int NCS   = 6;
  localparam int BUS_W = $clog2(NBUS);
  localparam int CS_W  = $clog2(NCS);

  typedef struct packed {
    logic             valid;
    logic [BUS_W-1:0] bus;
    logic [CS_W-1:0]  line;
  } route_t;

  // Device code to bus and flat chip-select line.
  function automatic route_t decode_sel(input logic [SEL_W-1:0] sel);
    route_t r;
    r = '0;
    case (sel)
      4'd0: begin r.valid = 1'b1; r.bus = 2'd0; r.line = 3'd0; end
      4'd2: begin r.valid = 1'b1; r.bus = 2'd1; r.line = 3'd1; end
      4'd3: begin r.valid = 1'b1; r.bus = 2'd1; r.line = 3'd2; end
      4'd4: begin r.valid = 1'b1; r.bus = 2'd2; r.line = 3'd3; end
      4'd5: begin r.valid = 1'b1; r.bus = 2'd2; r.line = 3'd4; end
      4'd6: begin r.valid = 1'b1; r.bus = 2'd2; r.line = 3'd5; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spi_route_decode.sv
module spi_route_decode
  import spi_route_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [NBUS-1:0]  bus_hit,
  output logic [NCS-1:0]   cs_hit
);
  route_t r;
  always_comb r = decode_sel(sel);

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    assign bus_hit[b] = r.valid && (r.bus == BUS_W'(b));
  end
  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_hit[c] = r.valid && (r.line == CS_W'(c));
  end
endmodule

// File: rtl/spi_ce_stage.sv
module spi_ce_stage #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (ce) q <= d;
  end
endmodule

// File: rtl/spi_bus_router.sv
module spi_bus_router
  import spi_route_pkg::*;
#(
  parameter logic [NBUS-1:0] READ_MASK = 3'b101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             x2_ce,
  input  logic             m_sclk,
  input  logic             m_mosi,
  input  logic             m_cs_n,
  input  logic [SEL_W-1:0] m_sel,
  output logic             m_miso,
  output logic [NBUS-1:0]  bus_sclk,
  output logic [NBUS-1:0]  bus_mosi,
  output logic [NCS-1:0]   bus_cs_n,
  input  logic [NBUS-1:0]  bus_miso
);
  localparam int S1_W = 3 + SEL_W;
  localparam int S2_W = 3 * NBUS + NCS;
  localparam logic [S1_W-1:0] S1_RST = {1'b0, 1'b0, 1'b1, {SEL_W{1'b0}}};
  localparam logic [S2_W-1:0] S2_RST = {{NBUS{1'b0}}, {NBUS{1'b0}}, {NCS{1'b1}}, {NBUS{1'b0}}};

  // Stage 1: capture master lines
  logic             s1_sclk, s1_mosi, s1_cs_n;
  logic [SEL_W-1:0] s1_sel;
  logic [S1_W-1:0]  s1_q;

  spi_ce_stage #(.W(S1_W), .RST_VAL(S1_RST)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .ce(x2_ce),
    .d({m_sclk, m_mosi, m_cs_n, m_sel}), .q(s1_q)
  );
  assign {s1_sclk, s1_mosi, s1_cs_n, s1_sel} = s1_q;

  // Steering
  logic [NBUS-1:0] hit_bus;
  logic [NCS-1:0]  hit_cs;

  spi_route_decode u_dec (.sel(s1_sel), .bus_hit(hit_bus), .cs_hit(hit_cs));

  logic [NBUS-1:0] sclk_d, mosi_d;
  logic [NCS-1:0]  cs_n_d;
  assign sclk_d = {NBUS{s1_sclk}} & hit_bus;
  assign mosi_d = {NBUS{s1_mosi}} & hit_bus;
  assign cs_n_d = ~(hit_cs & {NCS{~s1_cs_n}});

  // Stage 2: registered bus outputs plus the bus that owns them
  logic [NBUS-1:0] s2_hit;
  logic [S2_W-1:0] s2_q;

  spi_ce_stage #(.W(S2_W), .RST_VAL(S2_RST)) u_stage2 (
    .clk(clk), .rst_n(rst_n), .ce(x2_ce),
    .d({sclk_d, mosi_d, cs_n_d, hit_bus}), .q(s2_q)
  );
  assign {bus_sclk, bus_mosi, bus_cs_n, s2_hit} = s2_q;

  // Return path: select, then two enable-paced stages
  logic miso_sel, miso_s1;
  assign miso_sel = |(bus_miso & s2_hit & READ_MASK);

  spi_ce_stage #(.W(1), .RST_VAL(1'b0)) u_miso1 (
    .clk(clk), .rst_n(rst_n), .ce(x2_ce), .d(miso_sel), .q(miso_s1)
  );
  spi_ce_stage #(.W(1), .RST_VAL(1'b0)) u_miso2 (
    .clk(clk), .rst_n(rst_n), .ce(x2_ce), .d(miso_s1), .q(m_miso)
  );
endmodule

// File: rtl/spi_bus_router_chk.sv
module spi_bus_router_chk
  import spi_route_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            x2_ce,
  input logic            m_sclk,
  input logic            s1_sclk,
  input logic            s1_cs_n,
  input logic [NBUS-1:0] bus_sclk,
  input logic [NBUS-1:0] bus_mosi,
  input logic [NCS-1:0]  bus_cs_n,
  input logic            m_miso
);
  // R2: first stage takes the master clock on an enable edge
  assert_stage1_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    x2_ce |=> (s1_sclk == $past(m_sclk)));

  // R3: nothing moves without the enable
  assert_hold_without_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !x2_ce |=> ($stable(bus_sclk) && $stable(bus_mosi) && $stable(bus_cs_n) && $stable(m_miso)));

  // R7: at most one bus carries a clock or data
  assert_single_bus_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bus_sclk) <= 1) && ($countones(bus_mosi) <= 1));

  // R8: at most one chip select is low
  assert_cs_onehot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R9: an idle master chip select leaves every line high
  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x2_ce && s1_cs_n) |=> (&bus_cs_n));
endmodule

bind spi_bus_router spi_bus_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .x2_ce(x2_ce), .m_sclk(m_sclk),
  .s1_sclk(s1_sclk), .s1_cs_n(s1_cs_n), .bus_sclk(bus_sclk),
  .bus_mosi(bus_mosi), .bus_cs_n(bus_cs_n), .m_miso(m_miso)
);

// File: tb/spi_bus_router_tb_top.sv
module spi_bus_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x2_ce = 1'b0;
  logic       m_sclk = 1'b0, m_mosi = 1'b0, m_cs_n = 1'b1;
  logic [3:0] m_sel = 4'd0;
  logic       m_miso;
  logic [2:0] bus_sclk, bus_mosi;
  logic [5:0] bus_cs_n;
  logic [2:0] bus_miso = 3'b000;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_sclk = 3'b000, exp_mosi = 3'b000;
  logic [5:0] exp_cs_n = 6'h3f;

  always #4 clk = ~clk; // 125 MHz

  spi_bus_router dut_i (
    .clk(clk), .rst_n(rst_n), .x2_ce(x2_ce), .m_sclk(m_sclk), .m_mosi(m_mosi),
    .m_cs_n(m_cs_n), .m_sel(m_sel), .m_miso(m_miso), .bus_sclk(bus_sclk),
    .bus_mosi(bus_mosi), .bus_cs_n(bus_cs_n), .bus_miso(bus_miso)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) x2_ce = 1'b1;
    @(negedge clk) x2_ce = 1'b0;
  endtask

  // Bench-side map: bus index (3 = none) and flat line per code
  function automatic int bus_of(input logic [3:0] s);
    case (s)
      4'd0: return 0;
      4'd2, 4'd3: return 1;
      4'd4, 4'd5, 4'd6: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int line_of(input logic [3:0] s);
    if (s == 4'd0) return 0;
    if (s >= 4'd2 && s <= 4'd6) return int'(s) - 1;
    return 6;
  endfunction

  task automatic route_case(input logic [3:0] s, input logic ck, input logic d, input logic cs);
    logic [2:0] nsclk, nmosi;
    logic [5:0] ncs;
    int b, l;
    b = bus_of(s);
    l = line_of(s);
    nsclk = 3'b000; nmosi = 3'b000; ncs = 6'h3f;
    if (b < 3) begin nsclk[b] = ck; nmosi[b] = d; end
    if (l < 6 && !cs) ncs[l] = 1'b0;
    m_sel = s; m_sclk = ck; m_mosi = d; m_cs_n = cs;
    tick();
    check("R2 one stage only", {5'd0, bus_sclk}, {5'd0, exp_sclk});
    check("R2 one stage only cs", {2'd0, bus_cs_n}, {2'd0, exp_cs_n});
    tick();
    exp_sclk = nsclk; exp_mosi = nmosi; exp_cs_n = ncs;
    check(b == 0 ? "R4 sclk" : b == 1 ? "R5 sclk" : b == 2 ? "R6 sclk" : "R8 sclk",
          {5'd0, bus_sclk}, {5'd0, exp_sclk});
    check("R7 mosi steering", {5'd0, bus_mosi}, {5'd0, exp_mosi});
    check(cs ? "R9 cs idle" : (l == 6 ? "R8 no cs" : "R4 R5 R6 cs line"),
          {2'd0, bus_cs_n}, {2'd0, exp_cs_n});
  endtask

  task automatic test_reset();
    check("R1 sclk", {5'd0, bus_sclk}, 8'd0);
    check("R1 mosi", {5'd0, bus_mosi}, 8'd0);
    check("R1 cs", {2'd0, bus_cs_n}, 8'h3f);
    check("R1 miso", {7'd0, m_miso}, 8'd0);
  endtask

  task automatic test_all_codes();
    for (int s = 0; s < 16; s++) route_case(4'(s), 1'b1, 1'b1, 1'b0);
    route_case(4'd5, 1'b1, 1'b0, 1'b0);
    route_case(4'd3, 1'b0, 1'b1, 1'b0);
    route_case(4'd0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_cs_idle();
    route_case(4'd4, 1'b0, 1'b0, 1'b1);
    route_case(4'd2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic test_hold();
    route_case(4'd6, 1'b1, 1'b1, 1'b0);
    m_sel = 4'd0; m_sclk = 1'b0; m_mosi = 1'b0; m_cs_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 hold sclk", {5'd0, bus_sclk}, {5'd0, exp_sclk});
    check("R3 hold cs", {2'd0, bus_cs_n}, {2'd0, exp_cs_n});
  endtask

  task automatic miso_case(input logic [3:0] s, input logic [2:0] v, input logic exp, input string req);
    m_sel = s; m_cs_n = 1'b0; m_sclk = 1'b0; m_mosi = 1'b0; bus_miso = 3'b000;
    repeat (4) tick();
    bus_miso = v;
    tick();
    check({req, " early"}, {7'd0, m_miso}, 8'd0);
    tick();
    check(req, {7'd0, m_miso}, {7'd0, exp});
    bus_miso = 3'b000;
  endtask

  task automatic test_miso();
    miso_case(4'd0, 3'b001, 1'b1, "R10 bus0 read");
    miso_case(4'd0, 3'b110, 1'b0, "R10 bus0 other lines");
    miso_case(4'd3, 3'b111, 1'b0, "R10 write-only bus1");
    miso_case(4'd5, 3'b100, 1'b1, "R10 bus2 read");
    miso_case(4'd9, 3'b111, 1'b0, "R10 unused code");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_all_codes();
    test_cs_idle();
    test_hold();
    test_miso();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule